// File: doc/BRIEF.md
# Programmable Watchdog Timer with Indexed Byte Registers

This block watches over system software. Software programs a 24-bit time-out value, enables the block and then has to trigger it regularly. A prescaler divides the system clock down to a slow tick of about 32.768 kHz, and a tick counter compares its value with the programmed limit. If software stops triggering and the count reaches the limit, the block ends the wait in one of two ways. It either drives a system reset pulse of fixed length or raises an interrupt request that stays up.

Software reaches the block through two write strobes and a byte read port. One strobe loads an index register. The other writes the register the index selects, and the read port always shows that register. The limit sits in three consecutive byte registers, least significant byte first. A control register at the next index holds the enable, the reset-or-interrupt choice and a trigger bit that acts only when written. At the tick rate, one count is about 30.5 µs, so the range runs from about 30.5 µs up to about 512 s.

Top module: `wdog_top`

## Requirements
- R1: After reset both outputs are low, the control register (index 3Ch) reads 00h and all three limit bytes read FFh.
- R2: The limit bytes sit at index 39h (bits 7:0), 3Ah (bits 15:8) and 3Bh (bits 23:16) and read back as written. The control register at 3Ch has bit 0 = enable and bit 1 = mode (1 interrupt, 0 reset) and reads these back. Bit 2 = trigger always reads 0. Any other index reads 00h.
- R3: While the block is enabled, the tick count advances by one every CLK_DIV clocks. With limit L > 0, enabling together with a trigger (control write 07h) raises the interrupt on clock edge L*CLK_DIV+1 after the write edge.
- R4: In interrupt mode the interrupt output stays high until a trigger or a disable.
- R5: In reset mode an expiry drives the reset output high for exactly RST_LEN clocks, once per expiry, and the interrupt output stays low.
- R6: A trigger clears the tick count and the prescaler and drops a pending interrupt. The next expiry then comes L*CLK_DIV+1 edges after the trigger edge.
- R7: Clearing the enable bit stops the count and drops both outputs one clock later. No expiry occurs while the block is disabled.
- R8: If the count already meets the limit when the block is enabled (for example limit 0), the time-out output is asserted on the next clock edge.
- R9: Rewriting a limit byte while the block is enabled does not restart the count. The new value applies to the next comparison.
- R10: The interrupt and reset outputs are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| idxWe | input | 1 | Load the index register from wrData |
| dataWe | input | 1 | Write wrData into the indexed register |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Contents of the indexed register |
| wdReset | output | 1 | System reset pulse on expiry in reset mode |
| wdIrq | output | 1 | Interrupt request on expiry in interrupt mode |

## Verification
The checks assume that idxWe and dataWe are never high in the same cycle and that every write is a single-cycle strobe. The stimulus meets this by issuing each register access as an index write followed by a data write, in separate cycles. The count and output properties also assume a limit that stays put between writes. The directed scenarios change the limit only through complete register writes, and only the rewrite scenario does so while the block is enabled. The bench shortens the prescaler to four clocks and the reset pulse to five, so that exact expiry cycles can be counted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // control register bit positions
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_TRIG_BIT = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic en;       // watchdog enabled (registered)
    logic modeIrq;  // 1: interrupt on expiry, 0: reset pulse
    logic trig;     // single-cycle trigger strobe
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          LIMIT_BYTES = 3,
  parameter logic [7:0]  IDX_BASE    = 8'h39,
  localparam int         LIM_W       = 8 * LIMIT_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idxWe,
  input  logic             dataWe,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output wdStrobe_t        strobe,
  output logic [LIM_W-1:0] limit
);
  localparam logic [7:0] IDX_CTRL = IDX_BASE + 8'(LIMIT_BYTES);

  logic [7:0] idxReg;
  logic       enReg;
  logic       modeReg;
  logic       ctrlSel;
  logic [LIMIT_BYTES-1:0][7:0] rdPart;

  assign ctrlSel = (idxReg == IDX_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) idxReg <= '0;
    else if (idxWe) idxReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      modeReg <= 1'b0;
    end else if (dataWe && !idxWe && ctrlSel) begin
      enReg   <= wrData[CTRL_EN_BIT];
      modeReg <= wrData[CTRL_MODE_BIT];
    end
  end

  // one byte register per limit slice
  for (genvar g = 0; g < LIMIT_BYTES; g++) begin : gLimByte
    localparam logic [7:0] MY_IDX = IDX_BASE + 8'(g);
    logic [7:0] byteQ;
    always_ff @(posedge clk) begin
      if (!rstN) byteQ <= 8'hFF;
      else if (dataWe && !idxWe && idxReg == MY_IDX) byteQ <= wrData;
    end
    assign limit[g*8 +: 8] = byteQ;
    assign rdPart[g] = (idxReg == MY_IDX) ? byteQ : 8'h00;
  end

  always_comb begin
    rdData = 8'h00;
    if (ctrlSel) begin
      rdData[CTRL_EN_BIT]   = enReg;
      rdData[CTRL_MODE_BIT] = modeReg;
    end
    for (int b = 0; b < LIMIT_BYTES; b++) rdData = rdData | rdPart[b];
  end

  assign strobe.en      = enReg;
  assign strobe.modeIrq = modeReg;
  assign strobe.trig    = dataWe && !idxWe && ctrlSel && wrData[CTRL_TRIG_BIT];
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CLK_DIV = 3815,
  parameter int RST_LEN = 64,
  parameter int CNT_W   = 24,
  localparam int PW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int RW     = $clog2(RST_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cntVal,
  output logic             wdIrq,
  output logic             wdReset
);
  localparam logic [PW-1:0]    PRE_LAST = PW'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [PW-1:0] presc;
  logic          tick;
  logic          fired;
  logic          hit;
  logic [RW-1:0] rstCnt;

  assign tick = strobe.en && !strobe.trig && (presc == PRE_LAST);
  assign hit  = strobe.en && !strobe.trig && !fired && (cntVal >= limit);

  // prescaler: runs only while enabled, restarts on trigger
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.en || strobe.trig || tick) presc <= '0;
    else presc <= presc + 1'b1;
  end

  // tick counter, saturating, held while disabled
  always_ff @(posedge clk) begin
    if (!rstN || strobe.trig) cntVal <= '0;
    else if (tick && cntVal != CNT_MAX) cntVal <= cntVal + 1'b1;
  end

  // one expiry per trigger/enable window
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.en || strobe.trig) fired <= 1'b0;
    else if (hit) fired <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.en || strobe.trig) wdIrq <= 1'b0;
    else if (hit && strobe.modeIrq) wdIrq <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.en || strobe.trig) rstCnt <= '0;
    else if (hit && !strobe.modeIrq) rstCnt <= RW'(RST_LEN);
    else if (rstCnt != '0) rstCnt <= rstCnt - 1'b1;
  end

  assign wdReset = (rstCnt != '0);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int         CLK_DIV     = 3815,
  parameter int         RST_LEN     = 64,
  parameter int         LIMIT_BYTES = 3,
  parameter logic [7:0] IDX_BASE    = 8'h39,
  localparam int        CNT_W       = 8 * LIMIT_BYTES
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idxWe,
  input  logic       dataWe,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       wdReset,
  output logic       wdIrq
);
  wdStrobe_t        strobe;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cntVal;

  wdog_ctrl #(.LIMIT_BYTES(LIMIT_BYTES), .IDX_BASE(IDX_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .idxWe(idxWe), .dataWe(dataWe),
    .wrData(wrData), .rdData(rdData), .strobe(strobe), .limit(limit)
  );

  wdog_dp #(.CLK_DIV(CLK_DIV), .RST_LEN(RST_LEN), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .limit(limit),
    .cntVal(cntVal), .wdIrq(wdIrq), .wdReset(wdReset)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int RST_LEN = 64,
  parameter int CNT_W   = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             en,
  input logic             trig,
  input logic [CNT_W-1:0] cntVal,
  input logic             wdIrq,
  input logic             wdReset
);
  int hiCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !wdReset) hiCnt <= 0;
    else hiCnt <= hiCnt + 1;
  end

  // R10
  excl_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wdIrq && wdReset));

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!wdIrq && !wdReset));

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !trig) |=> $stable(cntVal));

  // R4
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdIrq && en && !trig) |=> wdIrq);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntVal) |-> (cntVal == $past(cntVal) + 1'b1 || cntVal == '0));

  // R6
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> (cntVal == '0 && !wdIrq));

  // R5
  rst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiCnt <= RST_LEN);
endmodule

bind wdog_top wdog_chk #(.RST_LEN(RST_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .en(strobe.en), .trig(strobe.trig),
  .cntVal(cntVal), .wdIrq(wdIrq), .wdReset(wdReset)
);

// File: tb/test_wdog_top.sv
module test_wdog_top;
  localparam int DIV = 4;
  localparam int RL  = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idxWe = 1'b0;
  logic       dataWe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       wdReset;
  logic       wdIrq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_top #(.CLK_DIV(DIV), .RST_LEN(RL)) i_wdog_top (
    .clk(clk), .rstN(rstN), .idxWe(idxWe), .dataWe(dataWe),
    .wrData(wrData), .rdData(rdData), .wdReset(wdReset), .wdIrq(wdIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); idxWe = 1'b1; wrData = idx;
    @(negedge clk); idxWe = 1'b0; dataWe = 1'b1; wrData = d;
    @(negedge clk); dataWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk); idxWe = 1'b1; wrData = idx;
    @(negedge clk); idxWe = 1'b0;
    d = rdData;
  endtask

  task automatic setLimit(input logic [23:0] v);
    regWrite(8'h39, v[7:0]);
    regWrite(8'h3A, v[15:8]);
    regWrite(8'h3B, v[23:16]);
  endtask

  // edges from mark until first negedge with wdIrq high; -1 if none
  task automatic pollIrq(input int mark, input int maxCyc, output int d);
    d = -1;
    for (int i = 0; i < maxCyc; i++) begin
      if (wdIrq) begin d = cyc - mark; return; end
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    logic [7:0] r;
    check(!wdIrq && !wdReset, "R1 outputs", {wdIrq, wdReset}, 0);
    regRead(8'h3C, r); check(r == 8'h00, "R1 ctrl", r, 8'h00);
    for (int k = 0; k < 3; k++) begin
      regRead(8'h39 + 8'(k), r); check(r == 8'hFF, "R1 limit byte", r, 8'hFF);
    end
  endtask

  task automatic tRegs();
    logic [7:0] r;
    setLimit(24'h563412);
    regRead(8'h39, r); check(r == 8'h12, "R2 byte 39h", r, 8'h12);
    regRead(8'h3A, r); check(r == 8'h34, "R2 byte 3Ah", r, 8'h34);
    regRead(8'h3B, r); check(r == 8'h56, "R2 byte 3Bh", r, 8'h56);
    regWrite(8'h3C, 8'h06);
    regRead(8'h3C, r); check(r == 8'h02, "R2 ctrl trig reads 0", r, 8'h02);
    regRead(8'h50, r); check(r == 8'h00, "R2 unused index", r, 8'h00);
    check(!wdIrq && !wdReset, "R7 disabled quiet", {wdIrq, wdReset}, 0);
  endtask

  task automatic tIrq();
    int m, d;
    setLimit(24'd5);
    regWrite(8'h3C, 8'h07);
    m = cyc;
    pollIrq(m, 200, d);
    check(d == 5*DIV + 1, "R3 irq expiry cycle", d, 5*DIV + 1);
    repeat (30) @(negedge clk);
    check(wdIrq == 1'b1, "R4 irq held", wdIrq, 1);
    regWrite(8'h3C, 8'h07);
    m = cyc;
    check(wdIrq == 1'b0, "R6 trigger drops irq", wdIrq, 0);
    pollIrq(m, 200, d);
    check(d == 5*DIV + 1, "R6 restart after trigger", d, 5*DIV + 1);
  endtask

  task automatic tDisable();
    bit seen = 1'b0;
    regWrite(8'h3C, 8'h02);
    @(negedge clk);
    check(wdIrq == 1'b0, "R7 disable clears irq", wdIrq, 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wdIrq || wdReset) seen = 1'b1;
    end
    check(!seen, "R7 no expiry while disabled", seen, 0);
  endtask

  task automatic tResetMode();
    int m, first, highs;
    bit irqSeen;
    first = -1; highs = 0; irqSeen = 1'b0;
    setLimit(24'd3);
    regWrite(8'h3C, 8'h05);
    m = cyc;
    for (int i = 0; i < 200; i++) begin
      if (wdReset) begin
        highs++;
        if (first < 0) first = cyc - m;
      end
      if (wdIrq) irqSeen = 1'b1;
      @(negedge clk);
    end
    check(first == 3*DIV + 1, "R5 reset pulse start", first, 3*DIV + 1);
    check(highs == RL, "R5 reset pulse length", highs, RL);
    check(!irqSeen, "R10 no irq in reset mode", irqSeen, 0);
    regWrite(8'h3C, 8'h00);
  endtask

  task automatic tZero();
    int m, d;
    setLimit(24'd0);
    regWrite(8'h3C, 8'h03);
    m = cyc;
    pollIrq(m, 50, d);
    check(d == 1, "R8 immediate expiry", d, 1);
    regWrite(8'h3C, 8'h00);
  endtask

  task automatic tRewrite();
    int m, d;
    setLimit(24'd32);
    regWrite(8'h3C, 8'h07);
    m = cyc;
    repeat (20) @(negedge clk);
    regWrite(8'h39, 8'd12);
    pollIrq(m, 300, d);
    check(d == 12*DIV + 1, "R9 rewrite keeps count", d, 12*DIV + 1);
    regWrite(8'h3C, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegs();
    tIrq();
    tDisable();
    tResetMode();
    tZero();
    tRewrite();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule